// File: doc/BRIEF.md
# Two-Master GPIO Bank with Per-Pin Edge Interrupts

This block is a bank of general-purpose pins that two processors share through two independent register ports. Each pin belongs to exactly one of the two processors at any time. The assignment is held in an ownership register, and only the primary port may change it. The owner of a pin sets its direction, its output level, its interrupt enable and its edge polarity. The owner also sees and clears the pin's interrupt status.

Pad inputs pass through a two-stage synchronizer into the block's clock domain. Edges are detected on the synchronized value, but only on pins that are configured as inputs. A detected edge of the chosen polarity sets a sticky status bit. The block drives one interrupt line per processor. Each line is raised by the enabled, pending pins that this processor owns.

Register map, shared by both ports (3-bit address): 0 ownership (bit set means secondary owns the pin), 1 direction (1 = output), 2 output data, 3 synchronized input (read only), 4 interrupt enable, 5 edge select (1 = rising, 0 = falling), 6 interrupt status (write 1 to clear). Address 7 reads as zero.

Top module: `gpio_dual_bank`

## Requirements
- R1: Reset gives these values: every pin is owned by the primary port, every pin is an input with output data 0, interrupt enables are 0, edge select is 0 (falling), all status bits are clear, and both interrupt outputs are low.
- R2: A write to address 0 from the primary port loads the ownership register. A write to address 0 from the secondary port is ignored. Both ports read the full ownership register.
- R3: A write to direction, output data, interrupt enable or edge select changes only the bits of pins that the writing port owns. Reads of addresses 1 to 6 return 0 in the bit positions of pins that the reading port does not own.
- R4: pad_oe equals the direction register and pad_out equals the output data register. Both change on the clock edge that commits the write.
- R5: The synchronized input is pad_in delayed by two clock edges. A read of address 3 shows a pad change after the second rising edge that follows it.
- R6: On a pin configured as an input, a change of the synchronized value in the selected direction (1 rising, 0 falling) sets the status bit one edge later. This is the third clock edge after the pad change. Pins configured as outputs never set status.
- R7: Status bits stay set until the owning port writes 1 to them at address 6. A clear attempt from the non-owning port has no effect. A new edge in the same cycle as a clear leaves the bit set.
- R8: irq_pri is the OR of enable AND status over the pins the primary port owns. irq_sec is the same OR over the secondary port's pins. When ownership changes, a pending bit is routed to its new owner.
- R9: Writes from both ports to the same register in the same cycle each take effect on their own pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Primary port write strobe |
| a_addr | input | 3 | Primary port register address |
| a_wdata | input | 14 | Primary port write data |
| a_rdata | output | 14 | Primary port read data (combinational) |
| b_wr | input | 1 | Secondary port write strobe |
| b_addr | input | 3 | Secondary port register address |
| b_wdata | input | 14 | Secondary port write data |
| b_rdata | output | 14 | Secondary port read data (combinational) |
| pad_in | input | 14 | Asynchronous pad inputs |
| pad_out | output | 14 | Pad output levels |
| pad_oe | output | 14 | Pad output enables |
| irq_pri | output | 1 | Interrupt to the primary processor |
| irq_sec | output | 1 | Interrupt to the secondary processor |

## Verification
The bench drives a step on all pads in both directions with a mixed edge selection. This shows whether rising and falling detection are kept apart per pin, and whether pins configured as outputs stay silent. Writes that cover every bit are issued from each port in turn and then from both ports at once. These show whether the ownership mask or the write arbitration leaks into foreign pins. A clear from the wrong port, a disabled enable and an ownership transfer of a pending pin each tell status from interrupt routing. The bench also confirms that a secondary-port write to address 0 leaves ownership unchanged.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_OWNER = 3'd0,
    REG_DIR   = 3'd1,
    REG_DOUT  = 3'd2,
    REG_DIN   = 3'd3,
    REG_IEN   = 3'd4,
    REG_EDGE  = 3'd5,
    REG_STAT  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] prev_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign sync_out = stage2_q;
  assign prev_out = prev_q;
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int W = 14
) (
  input  logic [W-1:0] ien,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] owner,
  output logic         irq_pri,
  output logic         irq_sec
);
  logic [W-1:0] live_pri;
  logic [W-1:0] live_sec;

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign live_pri[g] = ien[g] & stat[g] & ~owner[g];
    assign live_sec[g] = ien[g] & stat[g] &  owner[g];
  end

  assign irq_pri = |live_pri;
  assign irq_sec = |live_sec;
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_dual_pkg::*;
#(
  parameter int NPINS = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [NPINS-1:0]  a_wdata,
  output logic [NPINS-1:0]  a_rdata,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [NPINS-1:0]  b_wdata,
  output logic [NPINS-1:0]  b_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_pri,
  output logic              irq_sec
);
  typedef logic [NPINS-1:0] vec_t;

  // Bits that a port owns: primary owns the zeros, secondary the ones.
  function automatic vec_t owned_by(input vec_t owner, input logic sec);
    return sec ? owner : ~owner;
  endfunction

  // Masked write from both ports; masks are disjoint, so order is free.
  function automatic vec_t two_port_write(input vec_t cur,
                                          input logic hit_a, input vec_t dat_a, input vec_t msk_a,
                                          input logic hit_b, input vec_t dat_b, input vec_t msk_b);
    vec_t r;
    r = cur;
    if (hit_a) r = (r & ~msk_a) | (dat_a & msk_a);
    if (hit_b) r = (r & ~msk_b) | (dat_b & msk_b);
    return r;
  endfunction

  // Per-pin edge match against the selected polarity.
  function automatic vec_t edge_match(input vec_t cur, input vec_t prv, input vec_t rise);
    return (rise & cur & ~prv) | (~rise & ~cur & prv);
  endfunction

  vec_t owner_q, dir_q, dout_q, ien_q, edge_q, stat_q;
  vec_t own_a, own_b;
  vec_t sync_v, prev_v;
  vec_t edge_hit;
  vec_t clr_mask;
  vec_t dir_nxt, dout_nxt, ien_nxt, edge_nxt, stat_nxt;
  logic a_is_owner;

  gpio_sync_edge #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (sync_v),
    .prev_out (prev_v)
  );

  assign own_a      = owned_by(owner_q, 1'b0);
  assign own_b      = owned_by(owner_q, 1'b1);
  assign edge_hit   = ~dir_q & edge_match(sync_v, prev_v, edge_q);
  assign a_is_owner = a_wr && (a_addr == REG_OWNER);

  always_comb begin
    dir_nxt  = two_port_write(dir_q,  a_wr && a_addr == REG_DIR,  a_wdata, own_a,
                                      b_wr && b_addr == REG_DIR,  b_wdata, own_b);
    dout_nxt = two_port_write(dout_q, a_wr && a_addr == REG_DOUT, a_wdata, own_a,
                                      b_wr && b_addr == REG_DOUT, b_wdata, own_b);
    ien_nxt  = two_port_write(ien_q,  a_wr && a_addr == REG_IEN,  a_wdata, own_a,
                                      b_wr && b_addr == REG_IEN,  b_wdata, own_b);
    edge_nxt = two_port_write(edge_q, a_wr && a_addr == REG_EDGE, a_wdata, own_a,
                                      b_wr && b_addr == REG_EDGE, b_wdata, own_b);
    clr_mask = '0;
    if (a_wr && a_addr == REG_STAT) clr_mask = clr_mask | (a_wdata & own_a);
    if (b_wr && b_addr == REG_STAT) clr_mask = clr_mask | (b_wdata & own_b);
    stat_nxt = (stat_q & ~clr_mask) | edge_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      dir_q   <= '0;
      dout_q  <= '0;
      ien_q   <= '0;
      edge_q  <= '0;
      stat_q  <= '0;
    end else begin
      if (a_is_owner) owner_q <= a_wdata;
      dir_q  <= dir_nxt;
      dout_q <= dout_nxt;
      ien_q  <= ien_nxt;
      edge_q <= edge_nxt;
      stat_q <= stat_nxt;
    end
  end

  function automatic vec_t read_view(input logic [ADDR_W-1:0] addr, input vec_t msk);
    vec_t v;
    case (addr)
      REG_OWNER: v = owner_q;
      REG_DIR:   v = dir_q  & msk;
      REG_DOUT:  v = dout_q & msk;
      REG_DIN:   v = sync_v & msk;
      REG_IEN:   v = ien_q  & msk;
      REG_EDGE:  v = edge_q & msk;
      REG_STAT:  v = stat_q & msk;
      default:   v = '0;
    endcase
    return v;
  endfunction

  assign a_rdata = read_view(a_addr, own_a);
  assign b_rdata = read_view(b_addr, own_b);
  assign pad_out = dout_q;
  assign pad_oe  = dir_q;

  gpio_irq_route #(.W(NPINS)) u_route (
    .ien     (ien_q),
    .stat    (stat_q),
    .owner   (owner_q),
    .irq_pri (irq_pri),
    .irq_sec (irq_sec)
  );
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int NPINS = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             a_wr,
  input logic [2:0]       a_addr,
  input logic             b_wr,
  input logic [2:0]       b_addr,
  input logic [NPINS-1:0] owner_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] edge_hit,
  input logic             irq_pri,
  input logic             irq_sec
);
  p_owner_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (b_wr && b_addr == 3'd0 && !(a_wr && a_addr == 3'd0)) |=> $stable(owner_q));

  p_foreign_dir_r3: assert property (@(posedge clk) disable iff (rst)
    (b_wr && b_addr == 3'd1 && !a_wr) |=> (((dir_q ^ $past(dir_q)) & ~$past(owner_q)) == '0));

  p_output_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(dir_q)) == '0));

  p_edge_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (!(a_wr && a_addr == 3'd6) && !(b_wr && b_addr == 3'd6)) |=> ((~stat_q & $past(stat_q)) == '0));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_pri || irq_sec) |-> (stat_q != '0));
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_wr     (a_wr),
  .a_addr   (a_addr),
  .b_wr     (b_wr),
  .b_addr   (b_addr),
  .owner_q  (owner_q),
  .dir_q    (dir_q),
  .stat_q   (stat_q),
  .edge_hit (edge_hit),
  .irq_pri  (irq_pri),
  .irq_sec  (irq_sec)
);

// File: tb/gpio_dual_bank_bench.sv
module gpio_dual_bank_bench;
  localparam int N = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_wr = 1'b0, b_wr = 1'b0;
  logic [2:0] a_addr = '0, b_addr = '0;
  logic [N-1:0] a_wdata = '0, b_wdata = '0, pad_in = '0;
  logic [N-1:0] a_rdata, b_rdata, pad_out, pad_oe;
  logic irq_pri, irq_sec;

  int checks = 0;
  int failures = 0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  gpio_dual_bank u_gpio_dual_bank (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_pri(irq_pri), .irq_sec(irq_sec)
  );

  // Behavioural reference state, one bit per pin.
  bit m_own[N], m_dir[N], m_out[N], m_en[N], m_rise[N], m_st[N];
  bit m_s1[N], m_s2[N], m_pv[N];

  function automatic bit port_writes(input bit sec, input int id, input int pin, output bit val);
    bit mine;
    mine = sec ? m_own[pin] : !m_own[pin];
    if (!sec && a_wr && a_addr == id && mine) begin val = a_wdata[pin]; return 1'b1; end
    if ( sec && b_wr && b_addr == id && mine) begin val = b_wdata[pin]; return 1'b1; end
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        m_own[i] = 0; m_dir[i] = 0; m_out[i] = 0; m_en[i] = 0; m_rise[i] = 0;
        m_st[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0;
      end else begin
        bit v, hit, clr, nown, ndir, nout, nen, nrise;
        nown = m_own[i]; ndir = m_dir[i]; nout = m_out[i]; nen = m_en[i]; nrise = m_rise[i];
        if (a_wr && a_addr == 0) nown = a_wdata[i];
        for (int p = 0; p < 2; p++) begin
          if (port_writes(p[0], 1, i, v)) ndir  = v;
          if (port_writes(p[0], 2, i, v)) nout  = v;
          if (port_writes(p[0], 4, i, v)) nen   = v;
          if (port_writes(p[0], 5, i, v)) nrise = v;
        end
        clr = 0;
        for (int p = 0; p < 2; p++)
          if (port_writes(p[0], 6, i, v) && v) clr = 1;
        hit = 0;
        if (!m_dir[i]) hit = m_rise[i] ? (m_s2[i] && !m_pv[i]) : (!m_s2[i] && m_pv[i]);
        m_st[i] = hit || (m_st[i] && !clr);
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pad_in[i];
        m_own[i] = nown; m_dir[i] = ndir; m_out[i] = nout; m_en[i] = nen; m_rise[i] = nrise;
      end
    end
  end

  function automatic logic [N-1:0] exp_read(input bit sec, input logic [2:0] addr);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      bit mine;
      mine = sec ? m_own[i] : !m_own[i];
      case (addr)
        3'd0: r[i] = m_own[i];
        3'd1: r[i] = mine && m_dir[i];
        3'd2: r[i] = mine && m_out[i];
        3'd3: r[i] = mine && m_s2[i];
        3'd4: r[i] = mine && m_en[i];
        3'd5: r[i] = mine && m_rise[i];
        3'd6: r[i] = mine && m_st[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] addr);
    case (addr)
      3'd0: return "R2";
      3'd3: return "R5";
      3'd6: return "R6/R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h expected=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (started && !rst) begin
      logic [N-1:0] eo, ed;
      bit ip, is;
      ip = 0; is = 0;
      for (int i = 0; i < N; i++) begin
        eo[i] = m_out[i]; ed[i] = m_dir[i];
        if (m_en[i] && m_st[i]) begin
          if (m_own[i]) is = 1; else ip = 1;
        end
      end
      check("R4", "pad_oe", 32'(pad_oe), 32'(ed));
      check("R4", "pad_out", 32'(pad_out), 32'(eo));
      check("R8", "irq_pri", 32'(irq_pri), 32'(ip));
      check("R8", "irq_sec", 32'(irq_sec), 32'(is));
      check(tag_of(a_addr), "a_rdata", 32'(a_rdata), 32'(exp_read(0, a_addr)));
      check(tag_of(b_addr), "b_rdata", 32'(b_rdata), 32'(exp_read(1, b_addr)));
    end
  end

  task automatic wr(input bit sec, input logic [2:0] addr, input logic [N-1:0] d);
    @(negedge clk); #2;
    if (sec) begin b_wr = 1; b_addr = addr; b_wdata = d; end
    else     begin a_wr = 1; a_addr = addr; a_wdata = d; end
    @(negedge clk); #2;
    a_wr = 0; b_wr = 0;
  endtask

  task automatic wr_both(input logic [2:0] addr, input logic [N-1:0] da, input logic [N-1:0] db);
    @(negedge clk); #2;
    a_wr = 1; a_addr = addr; a_wdata = da;
    b_wr = 1; b_addr = addr; b_wdata = db;
    @(negedge clk); #2;
    a_wr = 0; b_wr = 0;
  endtask

  task automatic rd(input bit sec, input logic [2:0] addr, input logic [N-1:0] exp, input string tag);
    @(negedge clk); #2;
    if (sec) b_addr = addr; else a_addr = addr;
    #3;
    check(tag, sec ? "b read" : "a read", 32'(sec ? b_rdata : a_rdata), 32'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(4); #2; rst = 0;
    // R1 reset state
    rd(0, 3'd0, 14'h0000, "R1");
    rd(0, 3'd1, 14'h0000, "R1");
    rd(0, 3'd4, 14'h0000, "R1");
    rd(0, 3'd5, 14'h0000, "R1");
    rd(0, 3'd6, 14'h0000, "R1");
    check("R1", "irq idle", 32'({irq_pri, irq_sec}), 32'd0);
    // R2 ownership only from primary
    wr(0, 3'd0, 14'h3F00);
    wr(1, 3'd0, 14'h0000);
    rd(1, 3'd0, 14'h3F00, "R2");
    // R3 foreign bits ignored
    wr(0, 3'd1, 14'h3FFF);
    rd(1, 3'd1, 14'h0000, "R3");
    wr(1, 3'd1, 14'h3000);
    rd(0, 3'd1, 14'h00FF, "R3");
    check("R4", "pad_oe value", 32'(pad_oe), 32'h30FF);
    // R9 simultaneous writes
    wr_both(3'd2, 14'h15AA, 14'h2A55);
    idle(1);
    check("R9", "pad_out merge", 32'(pad_out), 32'h2AAA);
    wr_both(3'd1, 14'h00F0, 14'h0000);
    wr(0, 3'd5, 14'h000F);
    wr(0, 3'd4, 14'h00FF);
    wr(1, 3'd5, 14'h1500);
    wr(1, 3'd4, 14'h3F00);
    // R5 / R6 rising step on all pads
    @(negedge clk); #2; a_addr = 3'd3; pad_in = 14'h3FFF;
    @(negedge clk); #3;
    check("R5", "din after one edge", 32'(a_rdata), 32'h0000);
    @(negedge clk); #3;
    check("R5", "din after two edges", 32'(a_rdata), 32'h00FF);
    idle(3);
    rd(0, 3'd6, 14'h000F, "R6");
    rd(1, 3'd6, 14'h1500, "R6");
    check("R8", "both irqs", 32'({irq_pri, irq_sec}), 32'h3);
    // falling step: only falling-select input pins set
    @(negedge clk); #2; pad_in = 14'h0000;
    idle(5);
    rd(1, 3'd6, 14'h3F00, "R6");
    rd(0, 3'd6, 14'h000F, "R6");
    // R7 clear only from owner
    wr(1, 3'd6, 14'h3FFF);
    rd(0, 3'd6, 14'h000F, "R7");
    rd(1, 3'd6, 14'h0000, "R7");
    check("R8", "irq_sec after clear", 32'(irq_sec), 32'd0);
    wr(0, 3'd4, 14'h0000);
    check("R8", "irq_pri disabled", 32'(irq_pri), 32'd0);
    // R8 ownership transfer of pending pins
    wr(0, 3'd0, 14'h3F0F);
    rd(1, 3'd6, 14'h000F, "R8");
    wr(1, 3'd4, 14'h3F0F);
    check("R8", "irq_sec after transfer", 32'(irq_sec), 32'd1);
    wr(0, 3'd6, 14'h000F);
    rd(1, 3'd6, 14'h000F, "R7");
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule